// File: doc/BRIEF.md
# Ling Pseudo-Carry Adder

A purely combinational binary adder that takes two WIDTH-bit operands and a carry-in and produces the WIDTH-bit sum and the carry-out. Its lookahead network does not carry ordinary carries. It propagates a pseudo-carry H, defined so that H at position i+1 is the generate of bit i OR the real carry into bit i. A real carry is never formed inside the network. It is recovered only where each sum bit is built, as the transmit signal of the bit below ANDed with the pseudo-carry.

Each bit forms three signals from its operand bits: generate, propagate and transmit. Bits are gathered into groups of four. Each group reduces its bits to a group pseudo-generate with fan-in four and to a group transmit product. A second lookahead level combines the group pairs into the pseudo-carry at every group boundary. The carry-in is treated as a generate sitting below bit 0, with an implicit transmit of one. The block has no clock and no state. It is placed wherever a single-cycle add is needed on a datapath.

Top module: `ling_adder`

## Requirements
- R1: For every operand pair and carry-in, {carry_out, sum_out} equals op_a + op_b + carry_in taken as an unsigned (WIDTH+1)-bit value.
- R2: Each bit i forms generate g = a AND b, propagate p = a XOR b and transmit t = a OR b. For operand bits 00 the bit yields t=0 and g=0. For 01 and 10 it yields t=1 and g=0. For 11 it yields t=1 and g=1. Exactly one of p and g is set whenever t is set, and so a single-bit pair 1+0 gives a sum bit of 1 and 1+1 gives a carry into the next bit.
- R3: The carry-in acts as a generate below bit 0 with transmit one: the pseudo-carry at position 0 equals carry_in, so 0+0+1 gives 1 and all-ones+0+1 gives zero with carry_out 1.
- R4: The pseudo-carry at position i+1 equals g_i OR (real carry into bit i), so a set generate always forces the pseudo-carry above it high.
- R5: Each sum bit is p_i XOR (t_(i-1) AND H_i), where t_(-1) is one; the real carry exists only at this point.
- R6: A group of four bits passes a pseudo-carry out equal to its four-term pseudo-generate OR (the transmit product of its lower three bits and the top bit of the group below, AND the incoming pseudo-carry); a carry crossing any group boundary is delivered correctly.
- R7: The second lookahead level forms every group-boundary pseudo-carry directly from all lower groups, so a carry born in group 0 reaches the top group through a chain of all-transmitting groups.
- R8: carry_out equals t_(WIDTH-1) AND H_WIDTH; a generate in the top bit alone produces carry_out 1 with a zero sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The assertions are immediate checks evaluated whenever the block's inputs change. They take for granted that every operand and carry-in bit is a known 0 or 1 and that all three inputs move together as one vector. The bench never leaves an input undriven. It changes all inputs in a single step and lets the network settle for a time unit before it samples the outputs, so the checks see only settled values. Its stimulus spans exhaustive 8-bit operands, directed carry chains across group boundaries and random full-width values.

// File: rtl/ling_pkg.sv
package ling_pkg;
    localparam int GRP_BITS = 4;

    typedef struct packed {
        logic hg;   // group pseudo-generate
        logic tg;   // group transmit product
    } grp_pair_t;
endpackage

// File: rtl/ling_bit_cells.sv
module ling_bit_cells #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o,
    output logic [WIDTH-1:0] trans_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign gen_o[i]   = a_in[i] & b_in[i];
        assign prop_o[i]  = a_in[i] ^ b_in[i];
        assign trans_o[i] = a_in[i] | b_in[i];
    end
endmodule

// File: rtl/ling_group.sv
module ling_group
    import ling_pkg::*;
(
    input  logic [GRP_BITS-1:0] gen_i,
    input  logic [GRP_BITS-1:0] trans_i,
    input  logic                trans_below,
    input  logic                h_in,
    output logic [GRP_BITS-1:0] h_bits,
    output grp_pair_t           pair_o
);
    logic [GRP_BITS:1] loc_h;
    logic [GRP_BITS:1] loc_t;

    // H(b+k) = local pseudo-generate | transmit chain & H(b)
    always_comb begin
        for (int k = 1; k <= GRP_BITS; k++) begin
            logic acc;
            logic chain;
            acc   = 1'b0;
            chain = 1'b1;
            for (int m = k - 1; m >= 0; m--) begin
                acc   = acc | (chain & gen_i[m]);
                chain = chain & ((m == 0) ? trans_below : trans_i[m-1]);
            end
            loc_h[k] = acc;
            loc_t[k] = chain;
        end
    end

    always_comb begin
        h_bits[0] = h_in;
        for (int k = 1; k < GRP_BITS; k++) begin
            h_bits[k] = loc_h[k] | (loc_t[k] & h_in);
        end
        pair_o.hg = loc_h[GRP_BITS];
        pair_o.tg = loc_t[GRP_BITS];
    end
endmodule

// File: rtl/ling_lookahead.sv
module ling_lookahead
    import ling_pkg::*;
#(
    parameter int NGRP = 8
) (
    input  grp_pair_t [NGRP-1:0] pairs_i,
    input  logic                 h_base,
    output logic [NGRP:0]        h_bound
);
    // flat second-level lookahead: every boundary from all lower groups
    always_comb begin
        h_bound[0] = h_base;
        for (int j = 0; j < NGRP; j++) begin
            logic acc;
            logic chain;
            acc   = 1'b0;
            chain = 1'b1;
            for (int k = j; k >= 0; k--) begin
                acc   = acc | (chain & pairs_i[k].hg);
                chain = chain & pairs_i[k].tg;
            end
            h_bound[j+1] = acc | (chain & h_base);
        end
    end
endmodule

// File: rtl/ling_sum.sv
module ling_sum #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] prop_i,
    input  logic [WIDTH-1:0] trans_i,
    input  logic [WIDTH:0]   pseudo_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    logic [WIDTH-1:0] real_c;

    for (genvar i = 0; i < WIDTH; i++) begin : g_rec
        if (i == 0) begin : g_low
            assign real_c[i] = pseudo_i[0];
        end else begin : g_up
            assign real_c[i] = trans_i[i-1] & pseudo_i[i];
        end
        assign sum_o[i] = prop_i[i] ^ real_c[i];
    end

    assign cout_o = trans_i[WIDTH-1] & pseudo_i[WIDTH];
endmodule

// File: rtl/ling_adder.sv
module ling_adder
    import ling_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    localparam int NGRP = WIDTH / GRP_BITS;

    logic [WIDTH-1:0] bit_g;
    logic [WIDTH-1:0] bit_p;
    logic [WIDTH-1:0] bit_t;
    logic [WIDTH:0]   pseudo_h;
    logic [NGRP:0]    h_bound;
    grp_pair_t [NGRP-1:0] grp_pairs;

    ling_bit_cells #(.WIDTH(WIDTH)) u_bits (
        .a_in    (op_a),
        .b_in    (op_b),
        .gen_o   (bit_g),
        .prop_o  (bit_p),
        .trans_o (bit_t)
    );

    for (genvar j = 0; j < NGRP; j++) begin : g_grp
        logic t_below;
        if (j == 0) begin : g_first
            assign t_below = 1'b1;
        end else begin : g_rest
            assign t_below = bit_t[j*GRP_BITS-1];
        end
        ling_group u_grp (
            .gen_i       (bit_g[j*GRP_BITS +: GRP_BITS]),
            .trans_i     (bit_t[j*GRP_BITS +: GRP_BITS]),
            .trans_below (t_below),
            .h_in        (h_bound[j]),
            .h_bits      (pseudo_h[j*GRP_BITS +: GRP_BITS]),
            .pair_o      (grp_pairs[j])
        );
    end

    assign pseudo_h[WIDTH] = h_bound[NGRP];

    ling_lookahead #(.NGRP(NGRP)) u_look (
        .pairs_i (grp_pairs),
        .h_base  (carry_in),
        .h_bound (h_bound)
    );

    ling_sum #(.WIDTH(WIDTH)) u_sum (
        .prop_i   (bit_p),
        .trans_i  (bit_t),
        .pseudo_i (pseudo_h),
        .sum_o    (sum_out),
        .cout_o   (carry_out)
    );
endmodule

// File: rtl/ling_adder_chk.sv
module ling_adder_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic [WIDTH-1:0] bit_g,
    input logic [WIDTH-1:0] bit_p,
    input logic [WIDTH-1:0] bit_t,
    input logic [WIDTH:0]   pseudo_h
);
    logic [WIDTH:0]   ref_total;
    logic [WIDTH-1:0] ref_c;

    always_comb begin
        ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        ref_c     = op_a ^ op_b ^ sum_out;
    end

    always_comb begin
        assert_sum_matches_R1: assert ({carry_out, sum_out} == ref_total)
            else $error("R1 sum mismatch");
        for (int i = 0; i < WIDTH; i++) begin
            assert_bit_signals_R2: assert (!(bit_p[i] && bit_g[i]) && ((bit_p[i] | bit_g[i]) == bit_t[i]))
                else $error("R2 bit signals inconsistent at %0d", i);
            assert_gen_implies_h_R4: assert (!bit_g[i] || pseudo_h[i+1])
                else $error("R4 generate without pseudo-carry at %0d", i);
            assert_h_definition_R4: assert (pseudo_h[i+1] == (bit_g[i] | ref_c[i]))
                else $error("R4 pseudo-carry wrong at %0d", i);
        end
        assert_base_h_R3: assert (ref_c[0] == carry_in)
            else $error("R3 carry-in not seen at bit 0");
        assert_carry_out_R8: assert (carry_out == (bit_g[WIDTH-1] | (bit_t[WIDTH-1] & ref_c[WIDTH-1])))
            else $error("R8 carry-out wrong");
    end
endmodule

bind ling_adder ling_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .bit_g     (bit_g),
    .bit_p     (bit_p),
    .bit_t     (bit_t),
    .pseudo_h  (pseudo_h)
);

// File: tb/test_ling_adder.sv
`timescale 1ns/1ps
module test_ling_adder;
    localparam int WIDTH = 32;
    localparam int WATCH_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WIDTH-1:0] op_a = '0;
    logic [WIDTH-1:0] op_b = '0;
    logic             carry_in = 1'b0;
    logic [WIDTH-1:0] sum_out;
    logic             carry_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ling_adder #(.WIDTH(WIDTH)) i_ling_adder (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCH_CYCLES && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCH_CYCLES);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic apply_check(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                               input logic ci, input string tag);
        logic [WIDTH:0] expv;
        op_a = a;
        op_b = b;
        carry_in = ci;
        #1;
        expv = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci};
        checks++;
        if ({carry_out, sum_out} !== expv) begin
            failures++;
            $display("FAIL %s: a=%h b=%h ci=%b actual=%b_%h expected=%b_%h",
                     tag, a, b, ci, carry_out, sum_out, expv[WIDTH], expv[WIDTH-1:0]);
        end
    endtask

    task automatic t_zero_state();
        // R1: all-zero inputs give all-zero outputs
        apply_check('0, '0, 1'b0, "R1 zero");
    endtask

    task automatic t_bit_pairs();
        // R2: single-bit pairs 00, 01, 10, 11 at several positions
        for (int i = 0; i < WIDTH; i += 7) begin
            apply_check('0, '0, 1'b0, "R2 pair00");
            apply_check('0, WIDTH'(1) << i, 1'b0, "R2 pair01");
            apply_check(WIDTH'(1) << i, '0, 1'b0, "R2 pair10");
            apply_check(WIDTH'(1) << i, WIDTH'(1) << i, 1'b0, "R2 pair11");
        end
    endtask

    task automatic t_carry_in();
        // R3: carry-in as generate below bit 0
        apply_check('0, '0, 1'b1, "R3 cin only");
        apply_check('1, '0, 1'b1, "R3 cin full chain");
        apply_check('1, '1, 1'b1, "R3 max operands");
    endtask

    task automatic t_exhaustive8();
        // R5: every sum bit across all 8-bit operand pairs and both carry-ins
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                for (int c = 0; c < 2; c++) begin
                    apply_check(WIDTH'(a), WIDTH'(b), c[0], "R5 exhaustive8");
                end
            end
        end
    endtask

    task automatic t_group_boundary();
        // R6: carries crossing each 4-bit group boundary, R4 generate forcing H
        for (int j = 1; j < WIDTH / 4; j++) begin
            apply_check((WIDTH'(1) << (4 * j)) - 1, WIDTH'(1), 1'b0, "R6 boundary ripple");
            apply_check(WIDTH'(1) << (4 * j - 1), WIDTH'(1) << (4 * j - 1), 1'b0, "R4 generate at boundary");
        end
    endtask

    task automatic t_long_chain();
        // R7: carry from group 0 through all transmitting groups
        apply_check(32'h0FFF_FFFF, 32'h0000_0001, 1'b0, "R7 chain to top group");
        apply_check(32'h7FFF_FFFE, 32'h0000_0001, 1'b1, "R7 chain with cin");
        apply_check(32'h5555_5555, 32'hAAAA_AAAB, 1'b0, "R7 alternating transmit");
    endtask

    task automatic t_carry_out();
        // R8: carry-out from top-bit generate and from a full transmit chain
        apply_check(32'h8000_0000, 32'h8000_0000, 1'b0, "R8 top generate");
        apply_check(32'hFFFF_FFFF, 32'h0000_0000, 1'b0, "R8 no carry");
        apply_check(32'hFFFF_0000, 32'h0001_0000, 1'b0, "R8 upper half chain");
    endtask

    task automatic t_random();
        // R1: random full-width vectors
        for (int n = 0; n < 3000; n++) begin
            apply_check(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom), "R1 random");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_zero_state();
        t_bit_pairs();
        t_carry_in();
        t_group_boundary();
        t_long_chain();
        t_carry_out();
        t_exhaustive8();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule